// File: doc/BRIEF.md
# Adaptive Gear-Shifting PI Loop Filter

This block is the loop filter of an all-digital phase-locked loop. On each update strobe it takes one signed phase-error sample and a word holding the measured input period in system-clock cycles. From these it forms a proportional term and an integrator step. The sum of a programmable centre word, the integrator and the proportional term becomes the frequency-control word for a numerically controlled oscillator.

The loop bandwidth changes in two ways. A mode controller compares the error magnitude with two programmable thresholds. It picks a wide acquisition gear, an intermediate buffer gear or a narrow locked gear. Widening happens on the same update. Narrowing needs a run of consecutive updates and moves one gear at a time. A second right shift, taken from the bit length of the period word, lowers the gains when the input frequency is low. Every gain is a sum of arithmetic right shifts, so the block has no multiplier and no divider.

Top module: `dpll_loop_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the integrator clears, the mode becomes acquisition and `fcw` loads the value of `center` from that edge.
- R2: The `mode` output encodes acquisition as 2'b00, buffer as 2'b01 and locked as 2'b10, and never shows 2'b11. `locked` is high exactly while `mode` is 2'b10.
- R3: On an update, the target gear is found from the error magnitude |err|. If |err| >= `th_high` the target is acquisition. Otherwise, if |err| >= `th_low`, the target is buffer. Otherwise the target is locked. A target wider than the current gear is taken on that same update.
- R4: A target narrower than the current gear must hold for 4 consecutive updates, and on the 4th update the gear steps one level narrower. An update whose target is not narrower restarts the count. Acquisition can never go straight to locked.
- R5: The gain shifts (K = 2^-n) are as follows. Acquisition uses P = err>>>(2+s) and I = err>>>(4+s). Buffer uses P = err>>>(3+s) + err>>>(4+s) and I = err>>>(6+s). Locked uses P = err>>>(5+s) and I = err>>>(9+s). The gear used is the one chosen by that same update, and >>> is a flooring arithmetic shift.
- R6: The frequency shift s is L - 5, clamped to the range 0 to 8, where L is the index of the highest set bit of `period`. When `period` is zero, L is taken as 0.
- R7: The integrator is ACC_W bits signed. It adds I on each update and saturates at -2^(ACC_W-1) and 2^(ACC_W-1)-1 without wrapping.
- R8: On each update, `fcw` becomes `center` + integrator (after this update's step) + P, clamped to 0 .. 2^FCW_W-1. It is visible after that clock edge. Without an update, `fcw` and `mode` hold, even if `center` changes.
- R9: The integrator keeps its value across a gear change, so no mode switch resets or rescales it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | Update strobe for `err` |
| err | input | ERR_W | Signed phase-error sample |
| period | input | PER_W | Measured input period in clock cycles |
| th_high | input | ERR_W | Magnitude threshold between acquisition and buffer |
| th_low | input | ERR_W | Magnitude threshold between buffer and locked |
| center | input | FCW_W | Centre frequency word, loaded at reset and added to the output |
| fcw | output | FCW_W | Frequency-control word to the oscillator |
| mode | output | 2 | Current gear |
| locked | output | 1 | High while in the locked gear |

## Verification
The bench drives the dwell rule at its edge. Three narrow targets followed by a wide one must leave the gear unchanged, and an off-by-one counter would instead switch early or late. One update at exactly `th_high` or `th_low` tests the threshold comparison; a strict comparison would select the wrong gear. The most negative error and long runs of full-scale error push the integrator and the output into both clamps, where a wrapping adder would flip sign. Period words of zero, at the base, in the middle and far above the clamp check the frequency shift. A wrong clamp shows up as a proportional term that is too large or too small.

// File: rtl/lf_pkg.sv
package lf_pkg;
   typedef enum logic [1:0] {
      GEAR_ACQ  = 2'b00,
      GEAR_BUF  = 2'b01,
      GEAR_LOCK = 2'b10
   } lf_gear_e;

   localparam int SH_P_ACQ   = 2;
   localparam int SH_I_ACQ   = 4;
   localparam int SH_P_BUF_A = 3;
   localparam int SH_P_BUF_B = 4;
   localparam int SH_I_BUF   = 6;
   localparam int SH_P_LOCK  = 5;
   localparam int SH_I_LOCK  = 9;
endpackage

// File: rtl/lf_gear_ctrl.sv
module lf_gear_ctrl
   import lf_pkg::*;
#(
   parameter int ERR_W = 16,
   parameter int DWELL = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             upd,
   input  logic [ERR_W-1:0] mag,
   input  logic [ERR_W-1:0] th_high,
   input  logic [ERR_W-1:0] th_low,
   output lf_gear_e         gear_q,
   output lf_gear_e         gear_d
);
   localparam int CW = $clog2(DWELL + 1);

   if (DWELL < 1) begin : g_bad_dwell
      $error("DWELL must be at least 1");
   end

   lf_gear_e        target;
   logic [CW-1:0]   cnt_q, cnt_d;

   always_comb begin
      if (mag >= th_high)     target = GEAR_ACQ;
      else if (mag >= th_low) target = GEAR_BUF;
      else                    target = GEAR_LOCK;
   end

   always_comb begin
      gear_d = gear_q;
      cnt_d  = cnt_q;
      if (upd) begin
         if (target < gear_q) begin
            gear_d = target;
            cnt_d  = '0;
         end else if (target > gear_q) begin
            if (cnt_q == CW'(DWELL - 1)) begin
               gear_d = (gear_q == GEAR_ACQ) ? GEAR_BUF : GEAR_LOCK;
               cnt_d  = '0;
            end else begin
               cnt_d = cnt_q + CW'(1);
            end
         end else begin
            cnt_d = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         gear_q <= GEAR_ACQ;
         cnt_q  <= '0;
      end else begin
         gear_q <= gear_d;
         cnt_q  <= cnt_d;
      end
   end
endmodule

// File: rtl/lf_freq_shift.sv
module lf_freq_shift #(
   parameter int PER_W      = 24,
   parameter int LOG_BASE   = 5,
   parameter int MAX_FS     = 8,
   parameter bit FREQ_SCALE = 1'b1,
   localparam int FS_W      = $clog2(MAX_FS + 1)
) (
   input  logic [PER_W-1:0] period,
   output logic [FS_W-1:0]  fs
);
   localparam int LW = $clog2(PER_W) + 1;

   if (LOG_BASE + MAX_FS >= (1 << (LW - 1)) + PER_W) begin : g_bad_base
      $error("LOG_BASE + MAX_FS out of range for PER_W");
   end

   if (FREQ_SCALE) begin : g_scale
      logic [LW-1:0] lg;
      always_comb begin
         lg = '0;
         for (int i = 0; i < PER_W; i++)
            if (period[i]) lg = LW'(i);
      end
      always_comb begin
         if (lg >= LW'(LOG_BASE + MAX_FS)) fs = FS_W'(MAX_FS);
         else if (lg > LW'(LOG_BASE))      fs = FS_W'(lg - LW'(LOG_BASE));
         else                              fs = '0;
      end
   end else begin : g_fixed
      assign fs = '0;
      logic unused_period;
      assign unused_period = ^period;
   end
endmodule

// File: rtl/lf_gain_net.sv
module lf_gain_net
   import lf_pkg::*;
#(
   parameter int ERR_W = 16,
   parameter int FS_W  = 4
) (
   input  logic signed [ERR_W-1:0] err,
   input  lf_gear_e                gear,
   input  logic [FS_W-1:0]         fs,
   output logic signed [ERR_W:0]   p_term,
   output logic signed [ERR_W:0]   i_term
);
   localparam int SH_W = 6;

   function automatic logic signed [ERR_W:0] sra(input logic signed [ERR_W-1:0] v,
                                                 input int k,
                                                 input logic [FS_W-1:0] s);
      logic [SH_W-1:0] amt;
      logic signed [ERR_W-1:0] r;
      amt = SH_W'(k) + SH_W'(s);
      r   = v >>> amt;
      return (ERR_W + 1)'(r);
   endfunction

   always_comb begin
      case (gear)
         GEAR_BUF: begin
            p_term = sra(err, SH_P_BUF_A, fs) + sra(err, SH_P_BUF_B, fs);
            i_term = sra(err, SH_I_BUF, fs);
         end
         GEAR_LOCK: begin
            p_term = sra(err, SH_P_LOCK, fs);
            i_term = sra(err, SH_I_LOCK, fs);
         end
         default: begin
            p_term = sra(err, SH_P_ACQ, fs);
            i_term = sra(err, SH_I_ACQ, fs);
         end
      endcase
   end
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
   import lf_pkg::*;
#(
   parameter int ERR_W    = 16,
   parameter int PER_W    = 24,
   parameter int ACC_W    = 32,
   parameter int FCW_W    = 32,
   parameter int DWELL    = 4,
   parameter int LOG_BASE = 5,
   parameter int MAX_FS   = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             err_valid,
   input  logic [ERR_W-1:0] err,
   input  logic [PER_W-1:0] period,
   input  logic [ERR_W-1:0] th_high,
   input  logic [ERR_W-1:0] th_low,
   input  logic [FCW_W-1:0] center,
   output logic [FCW_W-1:0] fcw,
   output logic [1:0]       mode,
   output logic             locked
);
   localparam int FS_W = $clog2(MAX_FS + 1);
   localparam int SW   = FCW_W + 2;

   if (ACC_W > FCW_W || ERR_W > ACC_W) begin : g_bad_width
      $error("need ERR_W <= ACC_W <= FCW_W");
   end

   logic signed [ERR_W-1:0] err_s;
   logic [ERR_W-1:0]        mag;
   lf_gear_e                gear_q, gear_d;
   logic [FS_W-1:0]         fs;
   logic signed [ERR_W:0]   p_term, i_term;
   logic signed [ACC_W-1:0] acc_q, acc_d;
   logic signed [ACC_W:0]   acc_sum;
   logic signed [SW-1:0]    out_sum;
   logic [FCW_W-1:0]        fcw_d, fcw_q;

   assign err_s = $signed(err);
   assign mag   = err_s[ERR_W-1] ? ERR_W'(-err_s) : err;

   lf_gear_ctrl #(.ERR_W(ERR_W), .DWELL(DWELL)) u_gear (
      .clk(clk), .rst(rst), .upd(err_valid), .mag(mag),
      .th_high(th_high), .th_low(th_low),
      .gear_q(gear_q), .gear_d(gear_d)
   );

   lf_freq_shift #(.PER_W(PER_W), .LOG_BASE(LOG_BASE), .MAX_FS(MAX_FS)) u_fshift (
      .period(period), .fs(fs)
   );

   lf_gain_net #(.ERR_W(ERR_W), .FS_W(FS_W)) u_gain (
      .err(err_s), .gear(gear_d), .fs(fs), .p_term(p_term), .i_term(i_term)
   );

   always_comb begin
      acc_sum = (ACC_W + 1)'(acc_q) + (ACC_W + 1)'(i_term);
      if (acc_sum[ACC_W] != acc_sum[ACC_W-1])
         acc_d = acc_sum[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
      else
         acc_d = acc_sum[ACC_W-1:0];
   end

   always_comb begin
      out_sum = $signed({2'b00, center}) + SW'(acc_d) + SW'(p_term);
      if (out_sum[SW-1])      fcw_d = '0;
      else if (out_sum[SW-2]) fcw_d = '1;
      else                    fcw_d = out_sum[FCW_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         fcw_q <= center;
      end else if (err_valid) begin
         acc_q <= acc_d;
         fcw_q <= fcw_d;
      end
   end

   assign fcw    = fcw_q;
   assign mode   = gear_q;
   assign locked = (gear_q == GEAR_LOCK);
endmodule

// File: rtl/lf_checks.sv
module lf_checks #(
   parameter int ERR_W = 16,
   parameter int FCW_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             err_valid,
   input logic [ERR_W-1:0] err,
   input logic [ERR_W-1:0] th_high,
   input logic [FCW_W-1:0] center,
   input logic [FCW_W-1:0] fcw,
   input logic [1:0]       mode
);
   logic [ERR_W-1:0] mag_c;
   assign mag_c = err[ERR_W-1] ? ERR_W'(~err + 1'b1) : err;

   assert_reset_load_R1: assert property (@(posedge clk)
      rst |=> (fcw == $past(center) && mode == 2'b00));

   assert_mode_legal_R2: assert property (@(posedge clk) disable iff (rst)
      mode != 2'b11);

   assert_widen_now_R3: assert property (@(posedge clk) disable iff (rst)
      (err_valid && mag_c >= th_high) |=> mode == 2'b00);

   assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
      (err_valid && mode == 2'b00) |=> mode != 2'b10);

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !err_valid |=> ($stable(fcw) && $stable(mode)));
endmodule

bind dpll_loop_filter lf_checks #(.ERR_W(ERR_W), .FCW_W(FCW_W)) u_lf_checks (
   .clk(clk), .rst(rst), .err_valid(err_valid), .err(err), .th_high(th_high),
   .center(center), .fcw(fcw), .mode(mode)
);

// File: tb/test_dpll_loop_filter.sv
module test_dpll_loop_filter;
   localparam int CLK_PERIOD = 10;
   localparam int ERR_W = 16;
   localparam int PER_W = 24;
   localparam int ACC_W = 18;
   localparam int FCW_W = 32;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             err_valid = 1'b0;
   logic [ERR_W-1:0] err = '0;
   logic [PER_W-1:0] period = PER_W'(16);
   logic [ERR_W-1:0] th_high = ERR_W'(4000);
   logic [ERR_W-1:0] th_low = ERR_W'(500);
   logic [FCW_W-1:0] center = 32'h4000_0000;
   logic [FCW_W-1:0] fcw;
   logic [1:0]       mode;
   logic             locked;

   int    n_checks = 0;
   int    n_fails = 0;
   bit    done = 0;
   string cur_req = "R1";

   longint m_acc = 0, m_fcw = 0;
   int     m_mode = 0, m_cnt = 0;

   dpll_loop_filter #(.ERR_W(ERR_W), .PER_W(PER_W), .ACC_W(ACC_W), .FCW_W(FCW_W)) i_dpll_loop_filter (
      .clk(clk), .rst(rst), .err_valid(err_valid), .err(err), .period(period),
      .th_high(th_high), .th_low(th_low), .center(center),
      .fcw(fcw), .mode(mode), .locked(locked)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int fshift(input longint p);
      int lg = 0;
      for (int i = 0; i < PER_W; i++) if (p[i]) lg = i;
      if (lg - 5 > 8) return 8;
      if (lg > 5) return lg - 5;
      return 0;
   endfunction

   function automatic longint clampl(input longint v, input longint lo, input longint hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   task automatic model(input bit r, input bit v, input longint e);
      longint mag, p, i;
      int tgt, s;
      if (r) begin
         m_acc = 0; m_mode = 0; m_cnt = 0; m_fcw = longint'(center);
         return;
      end
      if (!v) return;
      mag = (e < 0) ? -e : e;
      tgt = (mag >= th_high) ? 0 : (mag >= th_low) ? 1 : 2;
      if (tgt < m_mode) begin
         m_mode = tgt; m_cnt = 0;
      end else if (tgt > m_mode) begin
         m_cnt++;
         if (m_cnt == 4) begin m_mode++; m_cnt = 0; end
      end else m_cnt = 0;
      s = fshift(longint'(period));
      case (m_mode)
         0: begin p = e >>> (2 + s); i = e >>> (4 + s); end
         1: begin p = (e >>> (3 + s)) + (e >>> (4 + s)); i = e >>> (6 + s); end
         default: begin p = e >>> (5 + s); i = e >>> (9 + s); end
      endcase
      m_acc = clampl(m_acc + i, -(64'sd1 <<< (ACC_W - 1)), (64'sd1 <<< (ACC_W - 1)) - 1);
      m_fcw = clampl(longint'(center) + m_acc + p, 0, (64'sd1 <<< FCW_W) - 1);
   endtask

   task automatic check(input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
      end
   endtask

   task automatic step(input bit r, input bit v, input int e);
      rst = r; err_valid = v; err = ERR_W'(e);
      model(r, v, longint'(e));
      @(negedge clk);
      check("fcw", longint'(fcw), m_fcw);
      check("mode", longint'(mode), longint'(m_mode));
      check("locked", longint'(locked), longint'(m_mode == 2));
   endtask

   task automatic run(input int n, input int e);
      for (int k = 0; k < n; k++) step(0, 1, e);
   endtask

   initial begin
      // R1: reset state
      cur_req = "R1";
      step(1, 0, 0); step(1, 0, 0); step(1, 1, 9000);
      check("fcw_reset", longint'(fcw), 64'h4000_0000);
      // R3: large errors, gear stays wide, threshold edge inclusive
      cur_req = "R3";
      period = PER_W'(64);
      run(3, 6000); run(2, -7000); step(0, 1, 4000);
      // R4: three narrow targets then a wide one restart the dwell
      cur_req = "R4";
      run(3, 1000); step(0, 1, 4500); run(3, 600);
      check("mode_before_dwell", longint'(mode), 0);
      step(0, 1, -700);
      check("mode_after_dwell", longint'(mode), 1);
      // R9: integrator carried across gear changes
      cur_req = "R9";
      run(4, 120); run(2, -80);
      // R2: locked flag and encoding
      cur_req = "R2";
      run(3, 30);
      check("locked_flag", longint'(locked), 1);
      step(0, 1, 500);
      check("mode_buf", longint'(mode), 1);
      step(0, 1, -4000);
      check("mode_acq", longint'(mode), 0);
      // R4: acquisition never jumps to locked
      cur_req = "R4";
      run(4, 10);
      check("one_step", longint'(mode), 1);
      run(4, 10);
      // R5: gains in every gear, both signs, fs 0
      cur_req = "R5";
      period = PER_W'(16);
      run(3, 333); run(3, -333); step(0, 1, -32768); run(3, 2500); run(4, -2501);
      run(2, 5555); run(4, 777); run(4, 77); run(2, -123);
      // R6: frequency shift values incl. zero and the clamp
      cur_req = "R6";
      foreach (period[b]) begin end
      period = '0;            run(2, 9000);
      period = PER_W'(32);    run(2, 9000);
      period = PER_W'(255);   run(2, -9000);
      period = PER_W'(8191);  run(2, 9000);
      period = PER_W'(1 << 13); run(2, 9000);
      period = PER_W'(1 << 20); run(2, -9000);
      period = '1;            run(2, 9000);
      // R8: hold without strobe, centre change ignored until update
      cur_req = "R8";
      period = PER_W'(16);
      center = 32'h1234_5678;
      for (int k = 0; k < 5; k++) step(0, 0, 20000);
      check("fcw_hold", longint'(fcw), m_fcw);
      step(0, 1, 0);
      // R7: integrator saturation both ways
      cur_req = "R7";
      run(90, 32767);
      run(180, -32768);
      run(90, 32767);
      // R8: output clamps at top and bottom
      cur_req = "R8";
      center = 32'hFFFF_FF00; run(3, 32767);
      check("fcw_top", longint'(fcw), 64'hFFFF_FFFF);
      center = 32'h0000_0000; run(180, -32768);
      check("fcw_bottom", longint'(fcw), 0);
      // R1: mid-run reset clears integrator
      cur_req = "R1";
      center = 32'h0100_0000;
      step(1, 1, 5000); run(2, 0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end
endmodule